// File: doc/BRIEF.md
# Motor Command Decoder with Acknowledge

This block sits behind a frame parser on a motor controller node. Each parsed frame arrives as a 12-bit identifier, a byte count and up to eight data bytes. The decoder checks whether the frame is addressed to its motor, updates that motor's configuration registers and answers every accepted command with a zero-length acknowledge identifier. Frames addressed elsewhere are handed unchanged to a forward port so that they can travel on to the other node or to the host.

The configuration consists of four 32-bit gain and speed fields (proportional, integral, derivative, target RPM), a 32-bit sample period in milliseconds, a speed/position mode flag and the motor enable. The motor is enabled only after all three parameter messages have arrived. Their receipt is tracked in a three-bit mask that is visible at the ports. A static strap selects whether the node serves motor A or motor B.

Top module: `motor_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, motor_en is 0, pos_mode is 0 (speed mode), rx_mask is 0, sample_ms is 10, all gain and RPM fields are 0, and ack_valid and fwd_valid are 0.
- R2: in_id[11:8] is the node prefix. With motor_b_sel low the node owns prefix 1, and with it high the node owns prefix 2. All other prefixes are foreign.
- R3: An own frame with suffix in_id[7:0]=0x00 and length 8 loads kp_gain from in_data[63:32] and ki_gain from in_data[31:0] (byte 0 sits in bits 63:56). It also sets rx_mask bit 0.
- R4: An own frame with suffix 0x01 and length 8 loads kd_gain from in_data[63:32] and target_rpm from in_data[31:0]. It also sets rx_mask bit 1.
- R5: An own frame with suffix 0x02 and length 4 loads sample_ms from in_data[63:32] and sets rx_mask bit 2.
- R6: When a parameter message would make rx_mask equal 7, motor_en becomes 1 and rx_mask becomes 0 on that same clock edge.
- R7: An own frame with suffix 0x04 and length 0 clears motor_en and rx_mask and leaves pos_mode unchanged.
- R8: An own frame with suffix 0x05 (or 0x06) and length 0 clears motor_en and rx_mask and sets pos_mode to 0 (or 1).
- R9: Every accepted command raises ack_valid on the edge that accepts it. The ack_id values are, for motor A and motor B respectively: 0x302/0x304 for suffix 00, 0x303/0x305 for 01, 0x306/0x307 for 02, 0x309/0x30B for 04, 0x30C/0x30D for 05 and 0x30E/0x30F for 06.
- R10: ack_valid and ack_id hold until an edge where ack_ready is high. While ack_valid is high, in_ready is low and no frame is taken.
- R11: An own-prefix frame with an unknown suffix or the wrong length is consumed. It changes no register and produces neither an acknowledge nor a forward.
- R12: A foreign frame produces a one-cycle fwd_valid after the accepting edge, with fwd_id, fwd_len and fwd_data equal to the input. It produces no acknowledge and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| motor_b_sel | input | 1 | Strap: 0 serves motor A, 1 serves motor B |
| in_valid | input | 1 | Parsed frame present |
| in_ready | output | 1 | Frame is taken when in_valid and in_ready are both high |
| in_id | input | 12 | Frame identifier |
| in_len | input | 4 | Data byte count |
| in_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| ack_valid | output | 1 | Acknowledge pending |
| ack_ready | input | 1 | Acknowledge accepted by the sender |
| ack_id | output | 12 | Acknowledge identifier |
| fwd_valid | output | 1 | One-cycle strobe for a forwarded frame |
| fwd_id | output | 12 | Forwarded identifier |
| fwd_len | output | 4 | Forwarded byte count |
| fwd_data | output | 64 | Forwarded data |
| kp_gain | output | 32 | Proportional gain bits |
| ki_gain | output | 32 | Integral gain bits |
| kd_gain | output | 32 | Derivative gain bits |
| target_rpm | output | 32 | Target speed in RPM |
| sample_ms | output | 32 | Speed sample period in ms |
| pos_mode | output | 1 | 0 speed mode, 1 position mode |
| motor_en | output | 1 | Motor enable |
| rx_mask | output | 3 | Received-parameter mask |

## Verification
The assertions assume that motor_b_sel stays fixed between resets and that ack_ready may take any value at any time. The bench changes the strap only while reset is held. It drives all inputs half a period away from the active edge, and it stalls ack_ready for a varying number of cycles so that new frames arrive while an acknowledge is still pending. The frame mix covers every own command, wrong lengths, unknown suffixes and foreign prefixes, including frames that carry acknowledge identifiers.

// File: rtl/mcd_pkg.sv
// Shared types and acknowledge encoding for the motor command decoder.
// Assumes 12-bit identifiers: a 4-bit node prefix over an 8-bit suffix.
package mcd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_GAIN_PI,
        CMD_GAIN_D_RPM,
        CMD_PERIOD,
        CMD_HALT,
        CMD_MODE_SPEED,
        CMD_MODE_POS
    } cmd_e;

    localparam int          ID_W       = 12;
    localparam logic [3:0]  ACK_PREFIX = 4'h3;

    // Acknowledge suffix for a command; motor_b selects the second column.
    function automatic logic [7:0] ack_suffix(cmd_e c, logic motor_b);
        case (c)
            CMD_GAIN_PI:    return motor_b ? 8'h04 : 8'h02;
            CMD_GAIN_D_RPM: return motor_b ? 8'h05 : 8'h03;
            CMD_PERIOD:     return motor_b ? 8'h07 : 8'h06;
            CMD_HALT:       return motor_b ? 8'h0B : 8'h09;
            CMD_MODE_SPEED: return motor_b ? 8'h0D : 8'h0C;
            CMD_MODE_POS:   return motor_b ? 8'h0F : 8'h0E;
            default:        return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/mcd_classify.sv
// Combinational frame classifier: splits an identifier into prefix and
// suffix, flags foreign frames and maps own frames with a valid length
// to a command. Own frames with a bad suffix or length map to CMD_NONE.
module mcd_classify
    import mcd_pkg::*;
#(
    parameter int LEN_W      = 4,
    parameter int BYTES_FULL = 8,
    parameter int BYTES_HALF = 4
) (
    input  logic [ID_W-1:0]  id,
    input  logic [LEN_W-1:0] len,
    input  logic [3:0]       own_prefix,
    output cmd_e             cmd,
    output logic             foreign
);

    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(BYTES_FULL);
    localparam logic [LEN_W-1:0] LEN_HALF = LEN_W'(BYTES_HALF);
    localparam logic [LEN_W-1:0] LEN_NONE = '0;

    // Decode prefix ownership, then suffix and length into a command.
    always_comb begin
        foreign = (id[ID_W-1:ID_W-4] != own_prefix);
        cmd     = CMD_NONE;
        if (!foreign) begin
            case (id[7:0])
                8'h00: if (len == LEN_FULL) cmd = CMD_GAIN_PI;
                8'h01: if (len == LEN_FULL) cmd = CMD_GAIN_D_RPM;
                8'h02: if (len == LEN_HALF) cmd = CMD_PERIOD;
                8'h04: if (len == LEN_NONE) cmd = CMD_HALT;
                8'h05: if (len == LEN_NONE) cmd = CMD_MODE_SPEED;
                8'h06: if (len == LEN_NONE) cmd = CMD_MODE_POS;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mcd_cfg_regs.sv
// Motor configuration registers and received-parameter mask.
// Assumes cmd_fire is a single-cycle pulse qualified by an accepted frame
// and that cmd is CMD_NONE-free whenever cmd_fire is high.
module mcd_cfg_regs
    import mcd_pkg::*;
#(
    parameter int FIELD_W    = 32,
    parameter int SAMPLE_RST = 10,
    parameter int N_GAIN     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_fire,
    input  cmd_e                 cmd,
    input  logic [2*FIELD_W-1:0] data,
    output logic [FIELD_W-1:0]   kp_gain,
    output logic [FIELD_W-1:0]   ki_gain,
    output logic [FIELD_W-1:0]   kd_gain,
    output logic [FIELD_W-1:0]   target_rpm,
    output logic [FIELD_W-1:0]   sample_ms,
    output logic                 pos_mode,
    output logic                 motor_en,
    output logic [2:0]           rx_mask
);

    localparam logic [2:0] MASK_ALL = 3'b111;

    logic [FIELD_W-1:0] field_hi, field_lo;
    logic [FIELD_W-1:0] gain_q [N_GAIN];
    logic [2:0]         set_bit;
    logic [2:0]         mask_next;

    assign field_hi = data[2*FIELD_W-1:FIELD_W];
    assign field_lo = data[FIELD_W-1:0];

    // One register per gain/RPM field; even slots take the first field.
    for (genvar gi = 0; gi < N_GAIN; gi++) begin : g_gain
        localparam cmd_e LOAD_CMD = (gi < 2) ? CMD_GAIN_PI : CMD_GAIN_D_RPM;
        // Load this slot from its half of the data when its command fires.
        always_ff @(posedge clk) begin
            if (!rst_n)
                gain_q[gi] <= '0;
            else if (cmd_fire && cmd == LOAD_CMD)
                gain_q[gi] <= (gi % 2 == 0) ? field_hi : field_lo;
        end
    end

    assign kp_gain    = gain_q[0];
    assign ki_gain    = gain_q[1];
    assign kd_gain    = gain_q[2];
    assign target_rpm = gain_q[3];

    // Map parameter commands to their mask bit.
    always_comb begin
        case (cmd)
            CMD_GAIN_PI:    set_bit = 3'b001;
            CMD_GAIN_D_RPM: set_bit = 3'b010;
            CMD_PERIOD:     set_bit = 3'b100;
            default:        set_bit = 3'b000;
        endcase
        mask_next = rx_mask | set_bit;
    end

    // Sample period register, reset to its default in ms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_ms <= FIELD_W'(SAMPLE_RST);
        else if (cmd_fire && cmd == CMD_PERIOD)
            sample_ms <= field_hi;
    end

    // Mask accumulation, enable gating and mode selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_mask  <= '0;
            motor_en <= 1'b0;
            pos_mode <= 1'b0;
        end else if (cmd_fire) begin
            case (cmd)
                CMD_GAIN_PI, CMD_GAIN_D_RPM, CMD_PERIOD: begin
                    if (mask_next == MASK_ALL) begin
                        motor_en <= 1'b1;
                        rx_mask  <= '0;
                    end else begin
                        rx_mask  <= mask_next;
                    end
                end
                CMD_HALT: begin
                    motor_en <= 1'b0;
                    rx_mask  <= '0;
                end
                CMD_MODE_SPEED, CMD_MODE_POS: begin
                    motor_en <= 1'b0;
                    rx_mask  <= '0;
                    pos_mode <= (cmd == CMD_MODE_POS);
                end
                default: ;
            endcase
        end
    end

    AST_MASK_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mask != MASK_ALL); // R6
    AST_ENABLE_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(motor_en) |-> rx_mask == 3'b000); // R6
    AST_HALT_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd == CMD_HALT) |=> (!motor_en && rx_mask == 3'b000)); // R7
    AST_POS_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd == CMD_MODE_POS) |=> (pos_mode && !motor_en)); // R8

endmodule

// File: rtl/mcd_ack_out.sv
// Acknowledge holding register: captures the acknowledge identifier for
// an accepted command and holds it until the consumer takes it.
// Assumes cmd_fire is never high while ack_valid is high.
module mcd_ack_out
    import mcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_fire,
    input  cmd_e            cmd,
    input  logic            motor_b,
    input  logic            ack_ready,
    output logic            ack_valid,
    output logic [ID_W-1:0] ack_id
);

    // Load a new acknowledge or retire the pending one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_id    <= '0;
        end else if (cmd_fire) begin
            ack_valid <= 1'b1;
            ack_id    <= {ACK_PREFIX, ack_suffix(cmd, motor_b)};
        end else if (ack_ready) begin
            ack_valid <= 1'b0;
        end
    end

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_id))); // R10
    AST_ACK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ack_id[ID_W-1:ID_W-4] == ACK_PREFIX); // R9
    AST_NO_FIRE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> !cmd_fire); // R10

endmodule

// File: rtl/motor_cmd_decoder.sv
// Motor command decoder top: accepts parsed frames, applies own commands
// to the configuration registers with an acknowledge, and forwards
// foreign frames unchanged. Input is held off while an ack is pending.
// Assumes motor_b_sel is static between resets.
module motor_cmd_decoder
    import mcd_pkg::*;
#(
    parameter int         LEN_W      = 4,
    parameter int         DATA_W     = 64,
    parameter int         SAMPLE_RST = 10,
    parameter logic [3:0] PREFIX_A   = 4'h1,
    parameter logic [3:0] PREFIX_B   = 4'h2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 motor_b_sel,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ID_W-1:0]      in_id,
    input  logic [LEN_W-1:0]     in_len,
    input  logic [DATA_W-1:0]    in_data,
    output logic                 ack_valid,
    input  logic                 ack_ready,
    output logic [ID_W-1:0]      ack_id,
    output logic                 fwd_valid,
    output logic [ID_W-1:0]      fwd_id,
    output logic [LEN_W-1:0]     fwd_len,
    output logic [DATA_W-1:0]    fwd_data,
    output logic [DATA_W/2-1:0]  kp_gain,
    output logic [DATA_W/2-1:0]  ki_gain,
    output logic [DATA_W/2-1:0]  kd_gain,
    output logic [DATA_W/2-1:0]  target_rpm,
    output logic [DATA_W/2-1:0]  sample_ms,
    output logic                 pos_mode,
    output logic                 motor_en,
    output logic [2:0]           rx_mask
);

    localparam int FIELD_W    = DATA_W / 2;
    localparam int BYTES_FULL = DATA_W / 8;
    localparam int BYTES_HALF = FIELD_W / 8;

    logic       accept;
    logic       foreign;
    logic       cmd_fire;
    logic [3:0] own_prefix;
    cmd_e       cmd;

    assign own_prefix = motor_b_sel ? PREFIX_B : PREFIX_A;
    assign in_ready   = !ack_valid;
    assign accept     = in_valid && in_ready;
    assign cmd_fire   = accept && (cmd != CMD_NONE);

    mcd_classify #(
        .LEN_W      (LEN_W),
        .BYTES_FULL (BYTES_FULL),
        .BYTES_HALF (BYTES_HALF)
    ) classify_i (
        .id         (in_id),
        .len        (in_len),
        .own_prefix (own_prefix),
        .cmd        (cmd),
        .foreign    (foreign)
    );

    mcd_cfg_regs #(
        .FIELD_W    (FIELD_W),
        .SAMPLE_RST (SAMPLE_RST)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd        (cmd),
        .data       (in_data),
        .kp_gain    (kp_gain),
        .ki_gain    (ki_gain),
        .kd_gain    (kd_gain),
        .target_rpm (target_rpm),
        .sample_ms  (sample_ms),
        .pos_mode   (pos_mode),
        .motor_en   (motor_en),
        .rx_mask    (rx_mask)
    );

    mcd_ack_out ack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .cmd       (cmd),
        .motor_b   (motor_b_sel),
        .ack_ready (ack_ready),
        .ack_valid (ack_valid),
        .ack_id    (ack_id)
    );

    // Forward strobe: one cycle per accepted foreign frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fwd_valid <= 1'b0;
        else
            fwd_valid <= accept && foreign;
    end

    // Forward payload capture; holds between forwarded frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_id   <= '0;
            fwd_len  <= '0;
            fwd_data <= '0;
        end else if (accept && foreign) begin
            fwd_id   <= in_id;
            fwd_len  <= in_len;
            fwd_data <= in_data;
        end
    end

    AST_FWD_IS_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fwd_id[ID_W-1:ID_W-4] != own_prefix); // R12
    AST_FWD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && foreign) |=> (fwd_valid && $stable(kp_gain) && $stable(motor_en))); // R12
    AST_BAD_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !foreign && cmd == CMD_NONE) |=> (!ack_valid && !fwd_valid && $stable(rx_mask))); // R11

endmodule

// File: tb/motor_cmd_decoder_tb_top.sv
// Bench for motor_cmd_decoder: a behavioural reference model updated on
// every rising edge and compared against the outputs on every falling edge.
`timescale 1ns/1ps
module motor_cmd_decoder_tb_top;

    localparam real PERIOD_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        motor_b_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_id = '0;
    logic [3:0]  in_len = '0;
    logic [63:0] in_data = '0;
    logic        ack_valid;
    logic        ack_ready = 1'b0;
    logic [11:0] ack_id;
    logic        fwd_valid;
    logic [11:0] fwd_id;
    logic [3:0]  fwd_len;
    logic [63:0] fwd_data;
    logic [31:0] kp_gain, ki_gain, kd_gain, target_rpm, sample_ms;
    logic        pos_mode, motor_en;
    logic [2:0]  rx_mask;

    int checks = 0;
    int errors = 0;
    int ack_delay = 0;
    int hold_cnt = 0;
    bit started = 0;
    bit done = 0;

    always #(PERIOD_NS / 2) clk = ~clk;

    motor_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .motor_b_sel(motor_b_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
        .in_len(in_len), .in_data(in_data),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_id(ack_id),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_len(fwd_len),
        .fwd_data(fwd_data), .kp_gain(kp_gain), .ki_gain(ki_gain),
        .kd_gain(kd_gain), .target_rpm(target_rpm), .sample_ms(sample_ms),
        .pos_mode(pos_mode), .motor_en(motor_en), .rx_mask(rx_mask)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_kp, m_ki, m_kd, m_rpm, m_smp;
    logic        m_pos, m_en, m_ack_v, m_fwd_v;
    logic [2:0]  m_mask;
    logic [11:0] m_ack_id, m_fwd_id;
    logic [3:0]  m_fwd_len;
    logic [63:0] m_fwd_data;

    function automatic logic [11:0] exp_ack(input logic b, input logic [7:0] suf);
        case (suf)
            8'h00: return b ? 12'h304 : 12'h302;
            8'h01: return b ? 12'h305 : 12'h303;
            8'h02: return b ? 12'h307 : 12'h306;
            8'h04: return b ? 12'h30B : 12'h309;
            8'h05: return b ? 12'h30D : 12'h30C;
            default: return b ? 12'h30F : 12'h30E;
        endcase
    endfunction

    function automatic void m_param(input int bitpos);
        logic [2:0] nm;
        nm = m_mask | 3'(1 << bitpos);
        if (nm == 3'd7) begin m_en = 1; m_mask = 0; end
        else m_mask = nm;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_kp = 0; m_ki = 0; m_kd = 0; m_rpm = 0; m_smp = 10;
            m_pos = 0; m_en = 0; m_mask = 0; m_ack_v = 0; m_ack_id = 0;
            m_fwd_v = 0; m_fwd_id = 0; m_fwd_len = 0; m_fwd_data = 0;
            started = 1;
        end else begin
            bit pend;
            bit ok;
            int own;
            pend = m_ack_v;
            m_fwd_v = 0;
            if (m_ack_v && ack_ready) m_ack_v = 0;
            if (in_valid && !pend) begin
                own = motor_b_sel ? 2 : 1;
                if (int'(in_id[11:8]) != own) begin
                    m_fwd_v = 1; m_fwd_id = in_id; m_fwd_len = in_len; m_fwd_data = in_data;
                end else begin
                    ok = 1;
                    case (in_id[7:0])
                        8'h00: if (in_len == 8) begin m_kp = in_data[63:32]; m_ki = in_data[31:0]; m_param(0); end else ok = 0;
                        8'h01: if (in_len == 8) begin m_kd = in_data[63:32]; m_rpm = in_data[31:0]; m_param(1); end else ok = 0;
                        8'h02: if (in_len == 4) begin m_smp = in_data[63:32]; m_param(2); end else ok = 0;
                        8'h04: if (in_len == 0) begin m_en = 0; m_mask = 0; end else ok = 0;
                        8'h05: if (in_len == 0) begin m_en = 0; m_mask = 0; m_pos = 0; end else ok = 0;
                        8'h06: if (in_len == 0) begin m_en = 0; m_mask = 0; m_pos = 1; end else ok = 0;
                        default: ok = 0;
                    endcase
                    if (ok) begin m_ack_v = 1; m_ack_id = exp_ack(motor_b_sel, in_id[7:0]); end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (kp_gain !== m_kp || ki_gain !== m_ki) begin errors++;
                $display("FAIL R3 kp/ki actual=%h/%h expected=%h/%h", kp_gain, ki_gain, m_kp, m_ki); end
            if (kd_gain !== m_kd || target_rpm !== m_rpm) begin errors++;
                $display("FAIL R4 kd/rpm actual=%h/%h expected=%h/%h", kd_gain, target_rpm, m_kd, m_rpm); end
            if (sample_ms !== m_smp) begin errors++;
                $display("FAIL R5 sample actual=%h expected=%h", sample_ms, m_smp); end
            if (motor_en !== m_en || rx_mask !== m_mask) begin errors++;
                $display("FAIL R6 en/mask actual=%b/%b expected=%b/%b", motor_en, rx_mask, m_en, m_mask); end
            if (pos_mode !== m_pos) begin errors++;
                $display("FAIL R8 pos_mode actual=%b expected=%b", pos_mode, m_pos); end
            if (ack_valid !== m_ack_v || in_ready !== !m_ack_v) begin errors++;
                $display("FAIL R10 ack_valid/in_ready actual=%b/%b expected=%b/%b", ack_valid, in_ready, m_ack_v, !m_ack_v); end
            if (m_ack_v && ack_id !== m_ack_id) begin errors++;
                $display("FAIL R9 ack_id actual=%h expected=%h", ack_id, m_ack_id); end
            if (fwd_valid !== m_fwd_v) begin errors++;
                $display("FAIL R12 fwd_valid actual=%b expected=%b", fwd_valid, m_fwd_v); end
            if (m_fwd_v && {fwd_id, fwd_len, fwd_data} !== {m_fwd_id, m_fwd_len, m_fwd_data}) begin errors++;
                $display("FAIL R12 fwd payload actual=%h %h %h expected=%h %h %h",
                         fwd_id, fwd_len, fwd_data, m_fwd_id, m_fwd_len, m_fwd_data); end
        end
    end

    // Acknowledge consumer with a programmable stall.
    always @(negedge clk) begin
        if (ack_valid === 1'b1 && hold_cnt < ack_delay) begin
            ack_ready = 1'b0; hold_cnt++;
        end else if (ack_valid === 1'b1) begin
            ack_ready = 1'b1; hold_cnt = 0;
        end else begin
            ack_ready = 1'b0; hold_cnt = 0;
        end
    end

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_n = 0; motor_b_sel = sel; in_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send(input logic [11:0] id, input logic [3:0] len, input logic [63:0] d);
        @(negedge clk);
        in_valid = 1; in_id = id; in_len = len; in_data = d;
        while (in_ready !== 1'b1) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    // Full command set for one node; pfx is the node prefix.
    task automatic run_node(input logic [3:0] pfx, input logic b);
        logic [3:0] other;
        logic [2:0] mk;
        other = (pfx == 4'h1) ? 4'h2 : 4'h1;
        ack_delay = 2;
        send({pfx, 8'h00}, 8, 64'h3F80_0000_4000_0000);
        chk("R3", "kp_gain", 64'(kp_gain), 64'h3F80_0000);
        chk("R9", "ack_id PI", 64'(ack_id), 64'(b ? 12'h304 : 12'h302));
        chk("R3", "rx_mask", 64'(rx_mask), 64'h1);
        send({pfx, 8'h01}, 8, 64'h3DCC_CCCD_0000_05DC);
        chk("R4", "target_rpm", 64'(target_rpm), 64'h5DC);
        mk = rx_mask;
        send({pfx, 8'h00}, 4, 64'hDEAD_BEEF_0000_0000);
        chk("R11", "no ack on bad length", 64'(ack_valid), 64'h0);
        chk("R11", "mask unchanged", 64'(rx_mask), 64'(mk));
        send({pfx, 8'h03}, 0, 64'h0);
        chk("R11", "no fwd on unknown suffix", 64'(fwd_valid), 64'h0);
        ack_delay = 0;
        send({pfx, 8'h02}, 4, 64'h0000_0014_FFFF_FFFF);
        chk("R5", "sample_ms", 64'(sample_ms), 64'h14);
        chk("R6", "motor_en", 64'(motor_en), 64'h1);
        chk("R6", "mask cleared", 64'(rx_mask), 64'h0);
        send({other, 8'h00}, 8, 64'h0123_4567_89AB_CDEF);
        chk("R12", "fwd_valid", 64'(fwd_valid), 64'h1);
        chk("R12", "fwd_data", fwd_data, 64'h0123_4567_89AB_CDEF);
        chk("R12", "no ack", 64'(ack_valid), 64'h0);
        send(12'h302, 0, 64'h0);
        chk("R12", "ack-id frame forwarded", 64'(fwd_id), 64'h302);
        ack_delay = 3;
        send({pfx, 8'h04}, 0, 64'h0);
        chk("R7", "stop disables", 64'(motor_en), 64'h0);
        chk("R9", "ack_id stop", 64'(ack_id), 64'(b ? 12'h30B : 12'h309));
        send({pfx, 8'h00}, 8, 64'h1111_2222_3333_4444);
        send({pfx, 8'h01}, 8, 64'h5555_6666_7777_8888);
        send({pfx, 8'h06}, 0, 64'h0);
        chk("R8", "position mode", 64'(pos_mode), 64'h1);
        chk("R8", "mask cleared", 64'(rx_mask), 64'h0);
        send({pfx, 8'h04}, 0, 64'h0);
        chk("R7", "mode kept on stop", 64'(pos_mode), 64'h1);
        send({pfx, 8'h05}, 0, 64'h0);
        chk("R8", "speed mode", 64'(pos_mode), 64'h0);
        chk("R9", "ack_id speed", 64'(ack_id), 64'(b ? 12'h30D : 12'h30C));
        ack_delay = 1;
        for (int k = 0; k < 12; k++) begin
            send({pfx, 8'(k % 3)}, (k % 3 == 2) ? 4'd4 : 4'd8, {32'(k * 7 + 1), 32'(k * 13)});
            if (k % 4 == 3) send({other, 8'(k)}, 4'(k % 9), 64'(k) << 20);
        end
        send({pfx, 8'h06}, 0, 64'h0);
        chk("R9", "ack_id pos", 64'(ack_id), 64'(b ? 12'h30F : 12'h30E));
        repeat (6) @(negedge clk);
    endtask

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        chk("R1", "motor_en", 64'(motor_en), 64'h0);
        chk("R1", "pos_mode", 64'(pos_mode), 64'h0);
        chk("R1", "rx_mask", 64'(rx_mask), 64'h0);
        chk("R1", "sample_ms", 64'(sample_ms), 64'd10);
        chk("R1", "ack/fwd", 64'({ack_valid, fwd_valid}), 64'h0);
        chk("R1", "kp_gain", 64'(kp_gain), 64'h0);
        run_node(4'h1, 1'b0);
        do_reset(1'b1);
        send(12'h100, 8, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R2", "motor A frame forwarded on B node", 64'(fwd_valid), 64'h1);
        chk("R2", "kp untouched", 64'(kp_gain), 64'h0);
        run_node(4'h2, 1'b1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD_NS * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule